// File: doc/BRIEF.md
# Chip-Select Address Range Decoder

This block tells which memory rank a physical address falls in. Four bounds registers each describe one rank. A register holds a start block and an end block in 16 MB units. Both ends of the range are inclusive, and the end covers the whole of its 16 MB block. A rank whose start and end are equal holds no memory and is skipped.

An address is offered together with a valid strobe. One clock later the block returns three results: a one-hot chip select, the index of the winning rank, and a miss flag. The miss flag is raised when no populated rank contains the address. The results are used to steer an access to a rank, or to attribute an error address to a rank.

The bounds registers are loaded through a simple write port. Each write selects one rank and writes its full 32-bit word.

Top module: `cs_range_decoder`

## Requirements
- R1: After reset, `hit_valid`, `cs_onehot`, `rank_idx` and `range_miss` are all zero. Every bounds register resets to zero, so a lookup made before any write is a miss.
- R2: The block number of an address is bits 39:24 of `addr`. A populated rank matches when start <= block <= end. An address whose bits 23:0 are all ones still matches in the end block.
- R3: A rank whose start field equals its end field never matches, even when the address block equals that value.
- R4: When more than one rank matches, the lowest rank index is selected.
- R5: When no rank matches, `range_miss` is 1, `cs_onehot` is 0 and `rank_idx` is 0. When a rank matches, `range_miss` is 0.
- R6: The results appear one cycle after `addr_valid` is sampled high, and `hit_valid` is high for that cycle. In a cycle after `addr_valid` was low, `hit_valid` is 0 and `cs_onehot`, `rank_idx` and `range_miss` keep their values.
- R7: A write with `cfg_we` high loads `cfg_wdata` into the rank chosen by `cfg_sel`. Bits 31:16 are the start field and bits 15:0 are the end field. A lookup presented in the same cycle as the write uses the old bounds; later lookups use the new bounds.
- R8: A write changes only the rank it selects; all other ranks keep their bounds.
- R9: `cs_onehot` has at most one bit set. When it is non-zero, the set bit is the one at position `rank_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Bounds register write strobe |
| cfg_sel | input | 2 | Rank whose bounds register is written |
| cfg_wdata | input | 32 | Bounds word: start in 31:16, end in 15:0 |
| addr_valid | input | 1 | Lookup request strobe |
| addr | input | 40 | Physical address to decode |
| hit_valid | output | 1 | Results below belong to the lookup of the previous cycle |
| cs_onehot | output | 4 | One-hot chip select of the winning rank |
| rank_idx | output | 2 | Index of the winning rank |
| range_miss | output | 1 | No populated rank contains the address |

## Verification
The hardest case to reach from the ports is a write and a lookup that land in the same cycle for the same rank. The lookup must see the old bounds, and only the next lookup may see the new ones. The bench drives both strobes on one falling edge and checks the result of that lookup, then the result of the following one. Overlapping ranges are another hard case, because the rank that should lose must match too. The bench covers them by building one range that overlaps a lower-indexed rank at its top, and another that covers a lower rank from below.

// File: rtl/cs_decode_pkg.sv
package cs_decode_pkg;
  localparam int FIELD_W = 16;
  localparam int WORD_W  = 2 * FIELD_W;

  typedef struct packed {
    logic [FIELD_W-1:0] first_blk;
    logic [FIELD_W-1:0] last_blk;
  } bounds_t;
endpackage

// File: rtl/csd_bounds_regs.sv
module csd_bounds_regs
  import cs_decode_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  localparam int IDX_W = $clog2(NUM_RANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_word,
  output bounds_t           bounds [NUM_RANKS]
);
  bounds_t bounds_q [NUM_RANKS];
  bounds_t bounds_d [NUM_RANKS];
  logic [NUM_RANKS-1:0] load_en;

  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_rank
    assign load_en[g] = wr_en && (wr_sel == IDX_W'(g));

    always_comb begin
      bounds_d[g] = bounds_q[g];
      if (load_en[g]) begin
        bounds_d[g] = bounds_t'(wr_word);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bounds_q[g] <= '0;
      end else if (load_en[g]) begin
        bounds_q[g] <= bounds_d[g];
      end
    end

    assign bounds[g] = bounds_q[g];
  end
endmodule

// File: rtl/csd_rank_match.sv
module csd_rank_match
  import cs_decode_pkg::*;
#(
  parameter int NUM_RANKS = 4
) (
  input  logic [FIELD_W-1:0]   blk,
  input  bounds_t              bounds [NUM_RANKS],
  output logic [NUM_RANKS-1:0] hit
);
  for (genvar g = 0; g < NUM_RANKS; g++) begin : g_cmp
    logic populated;
    logic above_first;
    logic below_last;

    assign populated   = (bounds[g].first_blk != bounds[g].last_blk);
    assign above_first = (blk >= bounds[g].first_blk);
    assign below_last  = (blk <= bounds[g].last_blk);
    assign hit[g]      = populated && above_first && below_last;
  end
endmodule

// File: rtl/csd_priority_pick.sv
module csd_priority_pick #(
  parameter int NUM_RANKS = 4,
  localparam int IDX_W = $clog2(NUM_RANKS)
) (
  input  logic [NUM_RANKS-1:0] hit,
  output logic [NUM_RANKS-1:0] pick_onehot,
  output logic [IDX_W-1:0]     pick_idx,
  output logic                 none
);
  always_comb begin
    pick_onehot = '0;
    pick_idx    = '0;
    for (int i = NUM_RANKS - 1; i >= 0; i--) begin
      if (hit[i]) begin
        pick_onehot    = '0;
        pick_onehot[i] = 1'b1;
        pick_idx       = IDX_W'(i);
      end
    end
    none = (hit == '0);
  end
endmodule

// File: rtl/cs_range_decoder.sv
module cs_range_decoder
  import cs_decode_pkg::*;
#(
  parameter int NUM_RANKS   = 4,
  parameter int ADDR_W      = 40,
  parameter int BLOCK_SHIFT = 24,
  localparam int IDX_W = $clog2(NUM_RANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_sel,
  input  logic [WORD_W-1:0]    cfg_wdata,
  input  logic                 addr_valid,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 hit_valid,
  output logic [NUM_RANKS-1:0] cs_onehot,
  output logic [IDX_W-1:0]     rank_idx,
  output logic                 range_miss
);
  bounds_t              bounds [NUM_RANKS];
  logic [FIELD_W-1:0]   blk;
  logic [NUM_RANKS-1:0] hit;
  logic [NUM_RANKS-1:0] pick_onehot;
  logic [IDX_W-1:0]     pick_idx;
  logic                 pick_none;

  logic                 valid_d, valid_q;
  logic [NUM_RANKS-1:0] cs_d, cs_q;
  logic [IDX_W-1:0]     idx_d, idx_q;
  logic                 miss_d, miss_q;

  assign blk = addr[BLOCK_SHIFT +: FIELD_W];

  csd_bounds_regs #(.NUM_RANKS(NUM_RANKS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .wr_sel  (cfg_sel),
    .wr_word (cfg_wdata),
    .bounds  (bounds)
  );

  csd_rank_match #(.NUM_RANKS(NUM_RANKS)) u_match (
    .blk    (blk),
    .bounds (bounds),
    .hit    (hit)
  );

  csd_priority_pick #(.NUM_RANKS(NUM_RANKS)) u_pick (
    .hit         (hit),
    .pick_onehot (pick_onehot),
    .pick_idx    (pick_idx),
    .none        (pick_none)
  );

  always_comb begin
    valid_d = addr_valid;
    cs_d    = cs_q;
    idx_d   = idx_q;
    miss_d  = miss_q;
    if (addr_valid) begin
      cs_d   = pick_onehot;
      idx_d  = pick_idx;
      miss_d = pick_none;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= '0;
      idx_q  <= '0;
      miss_q <= 1'b0;
    end else if (addr_valid) begin
      cs_q   <= cs_d;
      idx_q  <= idx_d;
      miss_q <= miss_d;
    end
  end

  assign hit_valid  = valid_q;
  assign cs_onehot  = cs_q;
  assign rank_idx   = idx_q;
  assign range_miss = miss_q;
endmodule

// File: rtl/cs_range_decoder_chk.sv
module cs_range_decoder_chk #(
  parameter int NUM_RANKS = 4,
  localparam int IDX_W = $clog2(NUM_RANKS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 addr_valid,
  input logic                 hit_valid,
  input logic [NUM_RANKS-1:0] cs_onehot,
  input logic [IDX_W-1:0]     rank_idx,
  input logic                 range_miss
);
  assert_result_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> hit_valid);

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> (!hit_valid && $stable(cs_onehot) && $stable(rank_idx) && $stable(range_miss)));

  assert_cs_onehot0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_onehot));

  assert_idx_agrees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !range_miss) |-> cs_onehot[rank_idx]);

  assert_miss_no_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_valid |-> (range_miss == (cs_onehot == '0)));

  assert_miss_idx_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    range_miss |-> (rank_idx == '0));
endmodule

bind cs_range_decoder cs_range_decoder_chk #(.NUM_RANKS(NUM_RANKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_valid (addr_valid),
  .hit_valid  (hit_valid),
  .cs_onehot  (cs_onehot),
  .rank_idx   (rank_idx),
  .range_miss (range_miss)
);

// File: tb/test_cs_range_decoder.sv
module test_cs_range_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  typedef struct packed {
    logic [39:0] a;
    logic [3:0]  cs;
    logic [1:0]  idx;
    logic        miss;
  } vec_t;

  // Bounds: r0 blocks 0..3, r1 4..7, r2 6..A (overlaps r1), r3 20..20 (empty)
  localparam vec_t VECS [NVEC] = '{
    '{40'h00_0000_0000, 4'b0001, 2'd0, 1'b0},
    '{40'h00_03FF_FFFF, 4'b0001, 2'd0, 1'b0},
    '{40'h00_0400_0000, 4'b0010, 2'd1, 1'b0},
    '{40'h00_0600_0000, 4'b0010, 2'd1, 1'b0},
    '{40'h00_0800_0000, 4'b0100, 2'd2, 1'b0},
    '{40'h00_0AFF_FFFF, 4'b0100, 2'd2, 1'b0},
    '{40'h00_0B00_0000, 4'b0000, 2'd0, 1'b1},
    '{40'h00_2000_0000, 4'b0000, 2'd0, 1'b1},
    '{40'hFF_FFFF_FFFF, 4'b0000, 2'd0, 1'b1},
    '{40'h01_0000_0000, 4'b0000, 2'd0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        addr_valid;
  logic [39:0] addr;
  logic        hit_valid;
  logic [3:0]  cs_onehot;
  logic [1:0]  rank_idx;
  logic        range_miss;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cs_range_decoder i_cs_range_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .addr_valid(addr_valid), .addr(addr),
    .hit_valid(hit_valid), .cs_onehot(cs_onehot), .rank_idx(rank_idx),
    .range_miss(range_miss)
  );

  task automatic check(input string req, input logic v, input logic [3:0] cs,
                       input logic [1:0] idx, input logic miss);
    checks++;
    if (hit_valid !== v || cs_onehot !== cs || rank_idx !== idx || range_miss !== miss) begin
      fails++;
      $display("FAIL %s: got v=%b cs=%b idx=%0d miss=%b, want v=%b cs=%b idx=%0d miss=%b",
               req, hit_valid, cs_onehot, rank_idx, range_miss, v, cs, idx, miss);
    end
  endtask

  task automatic write_bounds(input logic [1:0] sel, input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [39:0] a);
    @(negedge clk);
    addr = a; addr_valid = 1'b1;
    @(posedge clk);
    #1;
    addr_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles, want at most 5000", cycles);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    addr_valid = 1'b0; addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset outputs", 1'b0, 4'b0000, 2'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: all bounds zero, so block 0 misses
    lookup(40'h0);
    check("R1 lookup before writes", 1'b1, 4'b0000, 2'd0, 1'b1);

    // R7: start in 31:16, end in 15:0
    write_bounds(2'd0, 32'h0000_0003);
    write_bounds(2'd1, 32'h0004_0007);
    write_bounds(2'd2, 32'h0006_000A);
    write_bounds(2'd3, 32'h0020_0020);

    // Table walk covering R2, R3, R4, R5
    for (int i = 0; i < NVEC; i++) begin
      lookup(VECS[i].a);
      check($sformatf("R2/R3/R4/R5 vector %0d", i), 1'b1, VECS[i].cs, VECS[i].idx, VECS[i].miss);
    end

    // R6: idle cycle drops hit_valid, results hold despite new address
    lookup(40'h00_0500_0000);
    check("R6 lookup", 1'b1, 4'b0010, 2'd1, 1'b0);
    @(negedge clk);
    addr = 40'h00_0000_0000;
    @(posedge clk);
    #1;
    check("R6 hold when idle", 1'b0, 4'b0010, 2'd1, 1'b0);

    // R7: write and lookup in the same cycle, old bounds used
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = 32'h0020_0021;
    addr = 40'h00_2000_0000; addr_valid = 1'b1;
    @(posedge clk);
    #1;
    cfg_we = 1'b0; addr_valid = 1'b0;
    check("R7 same-cycle write sees old bounds", 1'b1, 4'b0000, 2'd0, 1'b1);
    lookup(40'h00_2000_0000);
    check("R7 later lookup sees new bounds", 1'b1, 4'b1000, 2'd3, 1'b0);
    lookup(40'h00_21FF_FFFF);
    check("R2 end block inclusive", 1'b1, 4'b1000, 2'd3, 1'b0);

    // R8: other ranks unchanged
    lookup(40'h00_0100_0000);
    check("R8 rank0 unchanged", 1'b1, 4'b0001, 2'd0, 1'b0);
    lookup(40'h00_0900_0000);
    check("R8 rank2 unchanged", 1'b1, 4'b0100, 2'd2, 1'b0);

    // R4: rank3 covers from below rank0; rank0 still wins at block 0
    write_bounds(2'd3, 32'h0000_0030);
    lookup(40'h00_0000_1234);
    check("R4 lower index wins", 1'b1, 4'b0001, 2'd0, 1'b0);
    lookup(40'h00_2500_0000);
    check("R4 only rank3 covers", 1'b1, 4'b1000, 2'd3, 1'b0);

    // R3: equal start/end at block 5 makes rank1 empty
    write_bounds(2'd1, 32'h0005_0005);
    lookup(40'h00_3100_0000);
    check("R5 beyond all ranks", 1'b1, 4'b0000, 2'd0, 1'b1);
    write_bounds(2'd3, 32'h0000_0000);
    lookup(40'h00_0500_0000);
    check("R3 empty rank never matches", 1'b1, 4'b0000, 2'd0, 1'b1);

    // R1: reset mid-run clears results and bounds
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset clears", 1'b0, 4'b0000, 2'd0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    lookup(40'h00_0100_0000);
    check("R1 bounds cleared by reset", 1'b1, 4'b0000, 2'd0, 1'b1);

    finish_run();
  end
endmodule